// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block shows four latched BCD digits on a time-shared seven-segment display. A prescaler makes a short scan pulse that repeats at a fixed period. Each rising edge of the pulse advances a four-state phase machine. The machine selects one digit position at a time, starting at the most significant position and ending at the least significant one. The selected digit is decoded to seven segment lines. Its digit strobe is driven for the rest of the scan period. While the scan pulse is high, no strobe is driven, which leaves a dark gap between digits and stops ghosting.

A two-bit display mode selects normal operation with leading-zero blanking, all segments dark, or normal operation with leading-zero blanking switched off. A parameter sets the segment sense for common-cathode or common-anode displays. An external scan signal can take the place of the internal pulse. When it does, it both advances the phase and blanks the strobes while it is high.

The phase machine has four states: `PH_D4`, `PH_D3`, `PH_D2` and `PH_D1`. Its transitions are `PH_D4→PH_D3`, `PH_D3→PH_D2`, `PH_D2→PH_D1` and `PH_D1→PH_D4`, each taken on a rising edge of the selected scan signal. Reset enters `PH_D4`. With no rising edge, every state holds.

Top module: `seg_scan_mux`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the phase in `PH_D4` and restarts the prescaler. In the first cycle after reset, all strobes are low. From the next cycle `dig_strobe` is 4'b1000.
- R2: Digit positions are strobed in the order D4, D3, D2, D1, D4, and so on. The phase advances one step per rising edge of the scan signal. Strobe bit 3 is D4 and bit 0 is D1, active high.
- R3: The internal scan signal repeats every `SCAN_PERIOD` clocks and is high for the first `SCAN_PULSE` clocks of each period. With the defaults (26, 1), each strobe is held for 25 consecutive cycles per period.
- R4: No more than one strobe is high at a time. All strobes are low whenever the selected scan signal is high.
- R5: While `ext_scan_en` is high, `ext_scan` replaces the internal pulse. The internal pulse then has no effect on the phase. The phase advances once per rising edge of `ext_scan`, and the strobes are low while `ext_scan` is high.
- R6: Digit value `v` is decoded to segments ordered {g,f,e,d,c,b,a} (bit 6 = g, bit 0 = a). The active-high codes for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F. Values 10 to 15 light no segment.
- R7: With `COMMON_ANODE` = 0, segments are active high. With `COMMON_ANODE` = 1, each segment line is the inverse of its active-high value.
- R8: `disp_mode` encoding: 2'b00 selects normal operation with leading-zero blanking. 2'b01 darkens every segment. 2'b10 turns leading-zero blanking off. 2'b11 behaves as 2'b00. Strobes keep scanning in every mode.
- R9: In a mode with leading-zero blanking, a digit is dark only when it and every more significant digit are zero. D1 is never blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_scan_en | input | 1 | Selects `ext_scan` as the scan signal |
| ext_scan | input | 1 | External scan signal |
| disp_mode | input | 2 | Display mode (see R8) |
| digits | input | 16 | Latched BCD digits, [15:12] = D4 … [3:0] = D1 |
| dig_strobe | output | 4 | One-hot digit strobes, bit 3 = D4 |
| seg | output | 7 | Segment lines {g,f,e,d,c,b,a} |

## Verification
The assertions assume that `digits` and `disp_mode` are steady around each sampling edge. They also assume that `ext_scan` changes only when the external scan source is selected. The blanking and one-hot properties hold in every cycle, but they presume the external signal is never toggled during reset. The bench drives every input one time unit after a rising edge, and it changes the scan source only while the display content is not under check.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    localparam int NUM_DIGITS = 4;
    localparam int BCD_W      = 4;
    localparam int SEG_W      = 7;
    localparam int DIGITS_W   = NUM_DIGITS * BCD_W;

    typedef enum logic [1:0] {
        PH_D4 = 2'd0,
        PH_D3 = 2'd1,
        PH_D2 = 2'd2,
        PH_D1 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_SEG_OFF = 2'b01,
        MODE_NO_LZB  = 2'b10,
        MODE_ALT     = 2'b11
    } disp_mode_e;

    function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] v);
        logic [SEG_W-1:0] s;
        unique case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scan_pulse_gen.sv
module scan_pulse_gen #(
    parameter int PERIOD    = 26,
    parameter int PULSE_LEN = 1
) (
    input  logic clk,
    input  logic rst,
    output logic pulse
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] LEN  = CW'(PULSE_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    always_comb pulse = (cnt < LEN);

    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R3

    AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> pulse); // R3

endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import seg_scan_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scan_in,
    output phase_e                phase,
    output logic [NUM_DIGITS-1:0] strobe
);
    phase_e state, state_nx;
    logic   scan_q;
    logic   rise;

    always_comb rise = scan_in && !scan_q;

    always_comb begin
        state_nx = state;
        if (rise) begin
            unique case (state)
                PH_D4: state_nx = PH_D3;
                PH_D3: state_nx = PH_D2;
                PH_D2: state_nx = PH_D1;
                PH_D1: state_nx = PH_D4;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_D4;
            scan_q <= 1'b1;
        end else begin
            state  <= state_nx;
            scan_q <= scan_in;
        end
    end

    always_comb begin
        phase  = state;
        strobe = '0;
        if (!scan_in) begin
            unique case (state)
                PH_D4: strobe = 4'b1000;
                PH_D3: strobe = 4'b0100;
                PH_D2: strobe = 4'b0010;
                PH_D1: strobe = 4'b0001;
            endcase
        end
    end

    AST_ADVANCE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        rise |=> (state != $past(state))); // R2

    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(state)); // R2

    AST_WRAP_TO_MSD: assert property (@(posedge clk) disable iff (rst)
        (rise && state == PH_D1) |=> (state == PH_D4)); // R2

endmodule

// File: rtl/seg_digit_decode.sv
module seg_digit_decode
    import seg_scan_pkg::*;
(
    input  phase_e                phase,
    input  logic [DIGITS_W-1:0]   digits,
    input  logic [1:0]            mode,
    output logic [SEG_W-1:0]      seg_on
);
    logic [NUM_DIGITS-1:0] is_zero;
    logic [NUM_DIGITS-1:0] lead_zero;
    logic [BCD_W-1:0]      cur;
    logic                  blank_lz;
    logic                  lzb_en;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_zero
        assign is_zero[i] = (digits[i*BCD_W +: BCD_W] == '0);
    end

    assign lead_zero[NUM_DIGITS-1] = is_zero[NUM_DIGITS-1];
    for (genvar i = NUM_DIGITS-2; i >= 0; i--) begin : g_lead
        assign lead_zero[i] = lead_zero[i+1] && is_zero[i];
    end

    always_comb begin
        unique case (phase)
            PH_D4: begin cur = digits[15:12]; blank_lz = lead_zero[3]; end
            PH_D3: begin cur = digits[11:8];  blank_lz = lead_zero[2]; end
            PH_D2: begin cur = digits[7:4];   blank_lz = lead_zero[1]; end
            PH_D1: begin cur = digits[3:0];   blank_lz = 1'b0;         end
        endcase
    end

    always_comb begin
        lzb_en = 1'b0;
        seg_on = bcd_to_seg(cur);
        unique case (disp_mode_e'(mode))
            MODE_NORMAL, MODE_ALT: lzb_en = 1'b1;
            MODE_NO_LZB:           lzb_en = 1'b0;
            MODE_SEG_OFF:          seg_on = '0;
        endcase
        if (lzb_en && blank_lz) seg_on = '0;
    end

endmodule

// File: rtl/seg_scan_mux.sv
module seg_scan_mux
    import seg_scan_pkg::*;
#(
    parameter int SCAN_PERIOD  = 26,
    parameter int SCAN_PULSE   = 1,
    parameter bit COMMON_ANODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_scan_en,
    input  logic        ext_scan,
    input  logic [1:0]  disp_mode,
    input  logic [15:0] digits,
    output logic [3:0]  dig_strobe,
    output logic [6:0]  seg
);
    localparam logic [SEG_W-1:0] DARK     = COMMON_ANODE ? 7'h7F : 7'h00;
    localparam logic [SEG_W-1:0] ZERO_PAT = COMMON_ANODE ? ~7'h3F : 7'h3F;

    logic             int_pulse;
    logic             scan_sel;
    phase_e           phase;
    logic [SEG_W-1:0] seg_on;

    scan_pulse_gen #(
        .PERIOD    (SCAN_PERIOD),
        .PULSE_LEN (SCAN_PULSE)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .pulse (int_pulse)
    );

    always_comb scan_sel = ext_scan_en ? ext_scan : int_pulse;

    scan_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .scan_in (scan_sel),
        .phase   (phase),
        .strobe  (dig_strobe)
    );

    seg_digit_decode u_dec (
        .phase  (phase),
        .digits (digits),
        .mode   (disp_mode),
        .seg_on (seg_on)
    );

    if (COMMON_ANODE) begin : g_ca
        assign seg = ~seg_on;
    end else begin : g_cc
        assign seg = seg_on;
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_strobe)); // R4

    AST_EXT_BLANK: assert property (@(posedge clk) disable iff (rst)
        (ext_scan_en && ext_scan) |-> (dig_strobe == 4'b0000)); // R5

    AST_SEG_DARK_OFF: assert property (@(posedge clk) disable iff (rst)
        (disp_mode == 2'b01) |-> (seg == DARK)); // R8

    AST_LSD_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (dig_strobe == 4'b0001 && disp_mode != 2'b01 && digits[3:0] == 4'd0)
        |-> (seg == ZERO_PAT)); // R9

endmodule

// File: tb/sim_seg_scan_mux.sv
module sim_seg_scan_mux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_scan_en = 1'b0;
    logic        ext_scan = 1'b0;
    logic [1:0]  disp_mode = 2'b00;
    logic [15:0] digits = 16'h0000;
    logic [3:0]  dig_strobe, dig_strobe_ca;
    logic [6:0]  seg, seg_ca;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seg_scan_mux u0 (
        .clk(clk), .rst(rst), .ext_scan_en(ext_scan_en), .ext_scan(ext_scan),
        .disp_mode(disp_mode), .digits(digits),
        .dig_strobe(dig_strobe), .seg(seg)
    );

    seg_scan_mux #(.COMMON_ANODE(1'b1)) u1 (
        .clk(clk), .rst(rst), .ext_scan_en(ext_scan_en), .ext_scan(ext_scan),
        .disp_mode(disp_mode), .digits(digits),
        .dig_strobe(dig_strobe_ca), .seg(seg_ca)
    );

    // {mode, digits, seg@D4, seg@D3, seg@D2, seg@D1}, active-high segment values
    localparam int NV = 10;
    localparam logic [45:0] VEC [NV] = '{
        {2'b00, 16'h1234, 7'h06, 7'h5B, 7'h4F, 7'h66},
        {2'b00, 16'h0000, 7'h00, 7'h00, 7'h00, 7'h3F},
        {2'b00, 16'h0050, 7'h00, 7'h00, 7'h6D, 7'h3F},
        {2'b10, 16'h0050, 7'h3F, 7'h3F, 7'h6D, 7'h3F},
        {2'b01, 16'h9876, 7'h00, 7'h00, 7'h00, 7'h00},
        {2'b11, 16'h0007, 7'h00, 7'h00, 7'h00, 7'h07},
        {2'b00, 16'h0A09, 7'h00, 7'h00, 7'h3F, 7'h6F},
        {2'b00, 16'h5678, 7'h6D, 7'h7D, 7'h07, 7'h7F},
        {2'b00, 16'h1000, 7'h06, 7'h3F, 7'h3F, 7'h3F},
        {2'b10, 16'h0000, 7'h3F, 7'h3F, 7'h3F, 7'h3F}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_strobe(input logic [3:0] want);
        int n = 0;
        while (dig_strobe !== want && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] s0;
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: first cycle after reset is blank, then D4
        @(negedge clk);
        chk("R1 blank after reset", {12'b0, dig_strobe}, 16'h0);
        @(negedge clk);
        chk("R1 D4 after reset", {12'b0, dig_strobe}, 16'h8);
        // R3: D4 held 25 cycles in total
        n = 1;
        @(negedge clk);
        while (dig_strobe == 4'b1000 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R3 strobe width", 16'(n), 16'd25);
        chk("R4 inter-digit gap", {12'b0, dig_strobe}, 16'h0);
        @(negedge clk);
        chk("R2 D4 then D3", {12'b0, dig_strobe}, 16'h4);

        // table walk: R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1;
            disp_mode = VEC[i][45:44];
            digits    = VEC[i][43:28];
            for (int p = 0; p < 4; p++) begin
                logic [6:0] e;
                e = VEC[i][27 - 7*p -: 7];
                @(negedge clk);
                wait_strobe(4'b1000 >> p);
                chk("R2 strobe order", {12'b0, dig_strobe}, 16'(4'b1000 >> p));
                chk("R6 R8 R9 segments", {9'b0, seg}, {9'b0, e});
                chk("R7 common anode", {9'b0, seg_ca}, {9'b0, ~e});
            end
        end

        // R1: reset in mid-scan
        @(negedge clk);
        wait_strobe(4'b0010);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 mid-scan reset blank", {12'b0, dig_strobe}, 16'h0);
        @(negedge clk);
        chk("R1 mid-scan reset D4", {12'b0, dig_strobe}, 16'h8);

        // R5: external scan source
        @(posedge clk); #1 ext_scan_en = 1'b1; ext_scan = 1'b0;
        @(negedge clk);
        s0 = dig_strobe;
        repeat (60) @(negedge clk);
        chk("R5 internal pulse ignored", {12'b0, dig_strobe}, {12'b0, s0});
        @(posedge clk); #1 ext_scan = 1'b1;
        @(negedge clk);
        chk("R5 ext high blanks", {12'b0, dig_strobe}, 16'h0);
        repeat (5) @(posedge clk);
        #1 ext_scan = 1'b0;
        @(negedge clk);
        chk("R5 single advance", {12'b0, dig_strobe}, {12'b0, s0[0], s0[3:1]});
        @(posedge clk); #1 ext_scan = 1'b1;
        @(posedge clk); #1 ext_scan = 1'b0;
        @(negedge clk);
        chk("R5 second advance", {12'b0, dig_strobe}, {12'b0, s0[1:0], s0[3:2]});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule